// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block turns a digital supply-good comparator signal into a system reset. It also holds the monitor's control and status register. The comparator output is synchronized. A turn-on timer models how long the monitor needs to settle after it is switched on. An active-low reset is driven whenever one of these causes is present: power-on, a software request, a premature selection of the monitor, or a supply dip while the monitor is armed. After the last cause clears, the reset is held low for a fixed number of cycles.

Software reaches two small registers through write strobes and a write-data byte. The control register carries the monitor enable and the live supply status. The source register carries the monitor-select bit and a power-on flag. The power-on flag tells software whether memory contents may be stale after power-up. The enable is restored only by power-on and survives every other reset. Selecting the monitor as a reset source before it has settled forces a reset.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: `ctl_rdata_o` bit 7 is the monitor enable, written from `wdata_i[7]` by `wr_ctl_i`. Bit 6 is the synchronized supply status. Bits 5..0 always read 0, and writing ones to them changes nothing.
- R2: While `por_i` is high, `rst_n_o` is 0, the enable is 1, the status reads 0, the power-on flag (`src_rdata_o` bit 0) is 1 and the select bit (`src_rdata_o` bit 1) is 0. This holds even if the enable was 0 before power-on.
- R3: A one-cycle `sw_rst_i` pulse clears the select bit and asserts reset. It leaves both the enable and the power-on flag unchanged, whether the enable is 0 or 1.
- R4: A supply below threshold causes no reset unless the monitor is both enabled and selected.
- R5: A write to the source register with `wdata_i[1]`=1 asserts reset if fewer than SETTLE_CYC cycles have passed since the enable rose. Once the monitor has settled, the same write causes no reset.
- R6: While the monitor is enabled and selected and the synchronized supply is low, `rst_n_o` stays 0. It rises once the supply has been back above threshold long enough for the synchronizer and the stretch.
- R7: The power-on flag survives supply-fail and software resets. A source-register write with `wdata_i[0]`=0 clears it. A write with 1 does not set it.
- R8: `rst_n_o` returns to 1 exactly HOLD_CYC clock edges after the last edge at which a reset cause was sampled.
- R9: Writing the enable to 0 restarts the turn-on timer, so a select written soon after re-enabling counts as premature.
- R10: The status bit follows `vdd_ok_i` through two flops, so a change on `vdd_ok_i` shows two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| sw_rst_i | input | 1 | Software reset request, one cycle |
| vdd_ok_i | input | 1 | Comparator output, 1 = supply above threshold |
| wr_ctl_i | input | 1 | Write strobe for the control register |
| wr_src_i | input | 1 | Write strobe for the source register |
| wdata_i | input | 8 | Write data |
| ctl_rdata_o | output | 8 | Control register: enable, status, zeros |
| src_rdata_o | output | 8 | Source register: select in bit 1, power-on flag in bit 0 |
| rst_n_o | output | 1 | System reset, active low |

## Verification
A timer that is wrong or has not been cleared shows up as a missing or spurious reset pulse on the first select write after re-enabling. That pulse appears one edge after the write. An enable lost to a software reset shows up in the control read-back on the next cycle. A wrong stretch counter or synchronizer depth moves the rising edge of `rst_n_o`, and the bench times that edge to the exact cycle. A power-on flag that is cleared or set wrongly is visible in the source read-back straight after the reset that disturbed it.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  // Width of a counter that must hold values 0..lim
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // Control register image: enable, status, reserved zeros
  function automatic logic [7:0] ctl_image(input logic en, input logic stat);
    return {en, stat, 6'b000000};
  endfunction

  // Source register image: select and power-on flag
  function automatic logic [7:0] src_image(input logic sel, input logic flag);
    return {6'b000000, sel, flag};
  endfunction
endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or posedge arst)
          if (arst) chain_q[0] <= 1'b0;
          else      chain_q[0] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or posedge arst)
          if (arst) chain_q[i] <= 1'b0;
          else      chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/supmon_settle.sv
module supmon_settle
  import supmon_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 10
) (
  input  logic clk,
  input  logic arst,
  input  logic en_i,
  output logic stable_o
);
  localparam int unsigned W = cnt_width(SETTLE_CYC);
  localparam logic [W-1:0] LIM = W'(SETTLE_CYC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or posedge arst)
    if (arst)              cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;

  assign stable_o = en_i && (cnt_q == LIM);
endmodule

// File: rtl/supmon_stretch.sv
module supmon_stretch
  import supmon_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic clk,
  input  logic arst,
  input  logic cause_i,
  output logic rst_n_o
);
  localparam int unsigned W = cnt_width(HOLD_CYC);
  localparam logic [W-1:0] LOAD = W'(HOLD_CYC);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or posedge arst)
    if (arst)            cnt_q <= LOAD;
    else if (cause_i)    cnt_q <= LOAD;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;

  assign rst_n_o = (cnt_q == '0);
endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
  import supmon_pkg::*;
#(
  parameter int unsigned SETTLE_CYC  = 100,
  parameter int unsigned HOLD_CYC    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_i,
  input  logic       sw_rst_i,
  input  logic       vdd_ok_i,
  input  logic       wr_ctl_i,
  input  logic       wr_src_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] ctl_rdata_o,
  output logic [7:0] src_rdata_o,
  output logic       rst_n_o
);
  logic en_q, sel_q, flag_q;
  logic vdd_s;
  logic mon_stable;
  logic early_sel;
  logic mon_cause;
  logic any_cause;
  logic unused_wbits;

  assign unused_wbits = ^{wdata_i[6], wdata_i[5:2]};

  supmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst(por_i), .d_i(vdd_ok_i), .q_o(vdd_s)
  );

  supmon_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .arst(por_i), .en_i(en_q), .stable_o(mon_stable)
  );

  // Enable: restored only by power-on
  always_ff @(posedge clk or posedge por_i)
    if (por_i)         en_q <= 1'b1;
    else if (wr_ctl_i) en_q <= wdata_i[7];

  // Select: cleared by power-on and software reset
  always_ff @(posedge clk or posedge por_i)
    if (por_i)         sel_q <= 1'b0;
    else if (sw_rst_i) sel_q <= 1'b0;
    else if (wr_src_i) sel_q <= wdata_i[1];

  // Power-on flag: set by power-on, cleared only by writing 0
  always_ff @(posedge clk or posedge por_i)
    if (por_i)                      flag_q <= 1'b1;
    else if (wr_src_i && !wdata_i[0]) flag_q <= 1'b0;

  assign early_sel = wr_src_i && wdata_i[1] && !mon_stable;
  assign mon_cause = en_q && sel_q && !vdd_s;
  assign any_cause = sw_rst_i || early_sel || mon_cause;

  supmon_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk(clk), .arst(por_i), .cause_i(any_cause), .rst_n_o(rst_n_o)
  );

  assign ctl_rdata_o = ctl_image(en_q, vdd_s);
  assign src_rdata_o = src_image(sel_q, flag_q);
endmodule

// File: rtl/supmon_chk.sv
module supmon_chk (
  input logic       clk,
  input logic       por_i,
  input logic       sw_rst_i,
  input logic       wr_ctl_i,
  input logic [7:0] wdata_i,
  input logic [7:0] ctl_rdata_o,
  input logic [7:0] src_rdata_o,
  input logic       rst_n_o,
  input logic       en_q,
  input logic       sel_q,
  input logic       flag_q,
  input logic       vdd_s,
  input logic       mon_stable,
  input logic       any_cause
);
  // R2: state seen in the first cycle after power-on ends
  a_r2_por_state: assert property (@(posedge clk) disable iff (por_i)
    $fell(por_i) |-> (!rst_n_o && ctl_rdata_o[7] && src_rdata_o[0] && !src_rdata_o[1]));

  // R3: software reset leaves the enable alone
  a_r3_sw_keeps_en: assert property (@(posedge clk) disable iff (por_i)
    (sw_rst_i && !wr_ctl_i) |=> (en_q == $past(en_q)));

  // R6: armed monitor with low supply drives reset
  a_r6_dip_resets: assert property (@(posedge clk) disable iff (por_i)
    (en_q && sel_q && !vdd_s) |=> !rst_n_o);

  // R7: power-on flag is never set outside power-on
  a_r7_flag_no_set: assert property (@(posedge clk) disable iff (por_i)
    !flag_q |=> !flag_q);

  // R8: any sampled cause drives reset on the next cycle
  a_r8_cause_low: assert property (@(posedge clk) disable iff (por_i)
    any_cause |=> !rst_n_o);

  // R9: disabling the monitor drops its settled state
  a_r9_disable_unsettles: assert property (@(posedge clk) disable iff (por_i)
    (wr_ctl_i && !wdata_i[7]) |=> !mon_stable);

  // R1: reserved bits never read nonzero
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (por_i)
    ctl_rdata_o[5:0] == 6'd0);
endmodule

bind supmon_rst_ctrl supmon_chk chk_i (
  .clk(clk), .por_i(por_i), .sw_rst_i(sw_rst_i), .wr_ctl_i(wr_ctl_i),
  .wdata_i(wdata_i), .ctl_rdata_o(ctl_rdata_o), .src_rdata_o(src_rdata_o),
  .rst_n_o(rst_n_o), .en_q(en_q), .sel_q(sel_q), .flag_q(flag_q),
  .vdd_s(vdd_s), .mon_stable(mon_stable), .any_cause(any_cause)
);

// File: tb/supmon_rst_ctrl_tb_top.sv
module supmon_rst_ctrl_tb_top;
  localparam int unsigned SETTLE = 10;
  localparam int unsigned HOLD   = 4;

  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       sw_rst_i = 1'b0;
  logic       vdd_ok_i = 1'b1;
  logic       wr_ctl_i = 1'b0;
  logic       wr_src_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] ctl_rdata_o, src_rdata_o;
  logic       rst_n_o;

  always #4 clk = ~clk;

  supmon_rst_ctrl #(.SETTLE_CYC(SETTLE), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .por_i(por_i), .sw_rst_i(sw_rst_i), .vdd_ok_i(vdd_ok_i),
    .wr_ctl_i(wr_ctl_i), .wr_src_i(wr_src_i), .wdata_i(wdata_i),
    .ctl_rdata_o(ctl_rdata_o), .src_rdata_o(src_rdata_o), .rst_n_o(rst_n_o)
  );

  typedef struct {
    string      tag;
    int         which;  // 0 = reset, 1 = control, 2 = source
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input int which, input logic [7:0] v);
    item_t it;
    it.tag = tag; it.which = which; it.exp = v;
    q.push_back(it);
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    wr_ctl_i = 1'b1; wdata_i = d; tick(); wr_ctl_i = 1'b0;
  endtask

  task automatic wr_src(input logic [7:0] d);
    wr_src_i = 1'b1; wdata_i = d; tick(); wr_src_i = 1'b0;
  endtask

  task automatic sw_pulse();
    sw_rst_i = 1'b1; tick(); sw_rst_i = 1'b0;
  endtask

  // Monitor: compare queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.which)
          0:       act = {7'd0, rst_n_o};
          1:       act = ctl_rdata_o;
          default: act = src_rdata_o;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R2: power-on state
    tick(3);
    expect_out("R2 rst low in por", 0, 8'h00);
    expect_out("R2 ctl in por", 1, 8'h80);
    expect_out("R2 src in por", 2, 8'h01);
    por_i = 1'b0;
    tick(1);
    expect_out("R10 status after one edge", 1, 8'h80);
    tick(1);
    expect_out("R10 status after two edges", 1, 8'hC0);
    tick(1);
    expect_out("R8 rst low edge 3", 0, 8'h00);
    tick(1);
    expect_out("R8 rst high edge 4", 0, 8'h01);
    tick(12);

    // R1: reserved bits ignored, enable written
    wr_ctl(8'hBF);
    expect_out("R1 write ones", 1, 8'hC0);
    wr_ctl(8'h3F);
    expect_out("R1 clear enable", 1, 8'h40);
    wr_ctl(8'h80);
    tick(12);

    // R4: supply low, not selected
    vdd_ok_i = 1'b0; tick(5);
    expect_out("R4 unselected no reset", 0, 8'h01);
    expect_out("R10 status low", 1, 8'h80);
    vdd_ok_i = 1'b1; tick(3);

    // R5: settled select causes no reset
    wr_src(8'h03);
    expect_out("R5 settled select", 2, 8'h03);
    expect_out("R5 no reset", 0, 8'h01);
    tick(2);
    expect_out("R5 still no reset", 0, 8'h01);

    // R6: dip while armed
    vdd_ok_i = 1'b0;
    tick(2);
    expect_out("R6 before sync", 0, 8'h01);
    tick(1);
    expect_out("R6 reset on dip", 0, 8'h00);
    tick(5);
    expect_out("R6 held low", 0, 8'h00);
    vdd_ok_i = 1'b1;
    tick(5);
    expect_out("R6 still low", 0, 8'h00);
    tick(1);
    expect_out("R6 released", 0, 8'h01);
    expect_out("R7 flag kept after dip", 2, 8'h03);

    // R4: selected but disabled
    wr_ctl(8'h00);
    expect_out("R4 disabled", 1, 8'h40);
    vdd_ok_i = 1'b0; tick(5);
    expect_out("R4 disabled no reset", 0, 8'h01);
    vdd_ok_i = 1'b1; tick(3);

    // R9 / R5: re-enable then select too early
    wr_ctl(8'h80);
    wr_src(8'h03);
    expect_out("R9 early select resets", 0, 8'h00);
    tick(3);
    expect_out("R8 early pulse held", 0, 8'h00);
    tick(1);
    expect_out("R8 early pulse ends", 0, 8'h01);
    tick(12);

    // R3: software reset with enable 1
    sw_pulse();
    expect_out("R3 sw reset low", 0, 8'h00);
    expect_out("R3 sel cleared flag kept", 2, 8'h01);
    expect_out("R3 enable kept", 1, 8'hC0);
    tick(3);
    expect_out("R8 sw held", 0, 8'h00);
    tick(1);
    expect_out("R8 sw released", 0, 8'h01);

    // R3: software reset with enable 0
    wr_ctl(8'h00);
    sw_pulse();
    expect_out("R3 enable stays 0", 1, 8'h40);
    tick(5);
    wr_ctl(8'h80);
    tick(12);

    // R7: flag clear semantics
    wr_src(8'h01);
    expect_out("R7 write 1 keeps", 2, 8'h01);
    wr_src(8'h00);
    expect_out("R7 write 0 clears", 2, 8'h00);
    wr_src(8'h01);
    expect_out("R7 write 1 no set", 2, 8'h00);
    sw_pulse();
    tick(5);
    expect_out("R7 sw no set", 2, 8'h00);

    // R2: power-on restores enable from 0
    wr_ctl(8'h00);
    por_i = 1'b1; tick(2);
    expect_out("R2 por restores", 1, 8'h80);
    expect_out("R2 por flag", 2, 8'h01);
    expect_out("R2 por rst", 0, 8'h00);
    por_i = 1'b0;
    tick(8);

    tick(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule